// File: doc/BRIEF.md
# Effective Address Unit

This block forms the operand address for one addressing-mode evaluation of a 16/32-bit CISC processor. A request pulse hands it a 3-bit mode code, an address-register number, an operand size, the register's current value and the program counter already advanced to the extension-word position. For modes that need extension words, the block then accepts one or two 16-bit words from the instruction stream, each marked by a valid strobe. When everything is in hand, it presents a one-cycle result: the effective address, whether a memory access may proceed, an address-register writeback value with its enable, the extra clock cycles the mode costs, and an address-error flag.

The control is a four-state machine: `ST_IDLE` (waiting for a request), `ST_EXT_HI` (waiting for the first or only extension word), `ST_EXT_LO` (waiting for the second word of an absolute long address) and `ST_DONE` (result valid for one cycle). Its transitions are: idle to `ST_DONE` on a request that needs no extension word, idle to `ST_EXT_HI` on a request that needs one or two words, `ST_EXT_HI` to `ST_EXT_LO` on a strobed word in absolute long mode, `ST_EXT_HI` or `ST_EXT_LO` to `ST_DONE` on the last strobed word, `ST_DONE` to idle always, and each wait state to itself while no word is strobed.

Mode codes: 0 register direct, 1 indirect, 2 postincrement, 3 predecrement, 4 register plus 16-bit displacement, 5 PC plus 16-bit displacement, 6 absolute short, 7 absolute long. Size codes: 0 byte, 1 word, 2 long, 3 treated as long.

Top module: `ea_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `mem_access`, `wb_en`, `addr_err` and `extra_cycles` are 0 and `ea` and `wb_val` are all zeros.
- R2: A request in mode 0 to 3 raises `done` in the cycle after the request edge; modes 4 to 6 raise it in the cycle after the edge that takes one strobed extension word; mode 7 after the edge that takes the second strobed word. `done` lasts one cycle, and while it is low every other output is zero. Inputs other than the strobe and word are captured at the request edge.
- R3: Postincrement (mode 2) gives the register value as `ea` with `mem_access` high, and writes back the register plus the size step (word 2, long 4).
- R4: Predecrement (mode 3) subtracts the size step from the register, uses the result as `ea` and writes that same value back.
- R5: The byte-size step for modes 2 and 3 is taken from a per-register table: 2 for the stack-pointer register (number 7 by default), 1 for every other register.
- R6: Mode 4 gives the register plus the extension word sign-extended to 32 bits; no writeback.
- R7: Mode 5 gives the supplied PC base plus the sign-extended extension word; no writeback.
- R8: Mode 6 gives the extension word sign-extended to 32 bits; mode 7 joins two words with the first as bits 31:16 and the second as bits 15:0.
- R9: When a word or long access (size not 0) has `ea` bit 0 set, `addr_err` is 1 and both `mem_access` and `wb_en` are 0; byte accesses at odd addresses raise no error.
- R10: Predecrement reports 2 extra cycles on `extra_cycles` unless `no_penalty` was high at the request; every other mode reports 0.
- R11: Register direct (mode 0) asserts neither `mem_access` nor `wb_en` and gives `ea` as zero; indirect (mode 1) gives the register value with no writeback.
- R12: A request pulse while a result is pending in a wait state is ignored: the pending evaluation completes with its own captured inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| mode | input | 3 | Addressing-mode code |
| reg_num | input | 3 | Address-register number |
| size | input | 2 | Operand size code |
| areg_val | input | 32 | Current value of the selected address register |
| pc_base | input | 32 | Program counter plus current extension offset |
| no_penalty | input | 1 | Context suppresses the predecrement cycle penalty |
| ext_valid | input | 1 | Extension word strobe |
| ext_word | input | 16 | Extension word from the instruction stream |
| done | output | 1 | Result valid for this cycle |
| ea | output | 32 | Effective address |
| mem_access | output | 1 | Memory access may proceed |
| wb_en | output | 1 | Address-register writeback enable |
| wb_val | output | 32 | Address-register writeback value |
| extra_cycles | output | 2 | Extra clock cycles charged by the mode |
| addr_err | output | 1 | Odd word/long address detected |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 16-bit extension words, eight address registers, the stack pointer at number 7 and a penalty of 2. With the stack pointer at the top register, byte postincrement and predecrement on register 7 versus a lower register show the table-driven step of 2 against 1, and the penalty of 2 makes the suppressed and unsuppressed predecrement cases tell apart on a 2-bit output. Gaps in the extension-word strobe, with stray requests inside them, bring the wait states and their self-loops within reach.

// File: rtl/ea_pkg.sv
package ea_pkg;

    typedef enum logic [2:0] {
        AM_DATA_REG = 3'd0,
        AM_IND      = 3'd1,
        AM_POSTINC  = 3'd2,
        AM_PREDEC   = 3'd3,
        AM_DISP     = 3'd4,
        AM_PCREL    = 3'd5,
        AM_ABS_S    = 3'd6,
        AM_ABS_L    = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_B   = 2'd0,
        SZ_W   = 2'd1,
        SZ_L   = 2'd2,
        SZ_RSV = 2'd3
    } osize_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXT_HI = 2'd1,
        ST_EXT_LO = 2'd2,
        ST_DONE   = 2'd3
    } eastate_e;

    // Number of extension words a mode consumes.
    function automatic logic [1:0] ext_count(input amode_e m);
        unique case (m)
            AM_DISP, AM_PCREL, AM_ABS_S: ext_count = 2'd1;
            AM_ABS_L:                    ext_count = 2'd2;
            default:                     ext_count = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/ea_step_table.sv
module ea_step_table
    import ea_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NREG   = 8,
    parameter int SP_REG = 7,
    localparam int RW    = $clog2(NREG)
) (
    input  logic [RW-1:0] reg_idx,
    input  osize_e        size,
    output logic [AW-1:0] step
);

    logic [AW-1:0] byte_step [NREG];

    // Stack pointer keeps word alignment on byte-sized adjustments.
    for (genvar g = 0; g < NREG; g++) begin : g_step
        if (g == SP_REG) begin : g_sp
            assign byte_step[g] = AW'(2);
        end else begin : g_plain
            assign byte_step[g] = AW'(1);
        end
    end

    always_comb begin
        unique case (size)
            SZ_B:    step = byte_step[reg_idx];
            SZ_W:    step = AW'(2);
            default: step = AW'(4);
        endcase
    end

endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
    import ea_pkg::*;
#(
    parameter int AW    = 32,
    parameter int EXT_W = 16,
    localparam int JW   = 2 * EXT_W
) (
    input  amode_e           mode,
    input  logic [AW-1:0]    areg,
    input  logic [AW-1:0]    pc_base,
    input  logic [EXT_W-1:0] ext_hi,
    input  logic [EXT_W-1:0] ext_lo,
    input  logic [AW-1:0]    step,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    wb_raw,
    output logic             need_access,
    output logic             need_wb
);

    logic [AW-1:0] disp_sx;
    logic [JW-1:0] joined;
    logic [AW-1:0] abs_long;

    assign disp_sx = {{(AW-EXT_W){ext_hi[EXT_W-1]}}, ext_hi};
    assign joined  = {ext_hi, ext_lo};

    if (AW <= JW) begin : g_trim
        assign abs_long = joined[AW-1:0];
    end else begin : g_pad
        assign abs_long = {{(AW-JW){1'b0}}, joined};
    end

    always_comb begin
        addr        = '0;
        wb_raw      = '0;
        need_access = 1'b1;
        need_wb     = 1'b0;
        unique case (mode)
            AM_DATA_REG: need_access = 1'b0;
            AM_IND:      addr = areg;
            AM_POSTINC: begin
                addr    = areg;
                wb_raw  = areg + step;
                need_wb = 1'b1;
            end
            AM_PREDEC: begin
                addr    = areg - step;
                wb_raw  = areg - step;
                need_wb = 1'b1;
            end
            AM_DISP:  addr = areg + disp_sx;
            AM_PCREL: addr = pc_base + disp_sx;
            AM_ABS_S: addr = disp_sx;
            AM_ABS_L: addr = abs_long;
        endcase
    end

endmodule

// File: rtl/ea_align_check.sv
module ea_align_check
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  osize_e        size,
    input  logic [AW-1:0] addr,
    input  logic          access,
    output logic          misaligned
);

    assign misaligned = access && (size != SZ_B) && addr[0];

endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW      = 32,
    parameter int EXT_W   = 16,
    parameter int NREG    = 8,
    parameter int SP_REG  = 7,
    parameter int PENALTY = 2,
    localparam int RW     = $clog2(NREG),
    localparam int CW     = $clog2(PENALTY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [RW-1:0]    reg_num,
    input  logic [1:0]       size,
    input  logic [AW-1:0]    areg_val,
    input  logic [AW-1:0]    pc_base,
    input  logic             no_penalty,
    input  logic             ext_valid,
    input  logic [EXT_W-1:0] ext_word,
    output logic             done,
    output logic [AW-1:0]    ea,
    output logic             mem_access,
    output logic             wb_en,
    output logic [AW-1:0]    wb_val,
    output logic [CW-1:0]    extra_cycles,
    output logic             addr_err
);

    eastate_e         state_q, state_d;
    amode_e           mode_q;
    osize_e           size_q;
    logic [RW-1:0]    reg_q;
    logic [AW-1:0]    areg_q, pc_q;
    logic             nopen_q;
    logic [EXT_W-1:0] hi_q, lo_q;

    logic [AW-1:0]    step, calc_ea, calc_wb;
    logic             calc_acc, calc_wb_en, odd_fault;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (ext_count(amode_e'(mode)) == 2'd0) state_d = ST_DONE;
                    else                                   state_d = ST_EXT_HI;
                end
            end
            ST_EXT_HI: begin
                if (ext_valid) begin
                    if (mode_q == AM_ABS_L) state_d = ST_EXT_LO;
                    else                    state_d = ST_DONE;
                end
            end
            ST_EXT_LO: begin
                if (ext_valid) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // ---------------- operand capture ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= AM_DATA_REG;
            size_q  <= SZ_B;
            reg_q   <= '0;
            areg_q  <= '0;
            pc_q    <= '0;
            nopen_q <= 1'b0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                mode_q  <= amode_e'(mode);
                size_q  <= osize_e'(size);
                reg_q   <= reg_num;
                areg_q  <= areg_val;
                pc_q    <= pc_base;
                nopen_q <= no_penalty;
            end
            if (state_q == ST_EXT_HI && ext_valid) hi_q <= ext_word;
            if (state_q == ST_EXT_LO && ext_valid) lo_q <= ext_word;
        end
    end

    // ---------------- datapath ----------------
    ea_step_table #(.AW(AW), .NREG(NREG), .SP_REG(SP_REG)) u_step (
        .reg_idx (reg_q),
        .size    (size_q),
        .step    (step)
    );

    ea_addr_calc #(.AW(AW), .EXT_W(EXT_W)) u_calc (
        .mode        (mode_q),
        .areg        (areg_q),
        .pc_base     (pc_q),
        .ext_hi      (hi_q),
        .ext_lo      (lo_q),
        .step        (step),
        .addr        (calc_ea),
        .wb_raw      (calc_wb),
        .need_access (calc_acc),
        .need_wb     (calc_wb_en)
    );

    ea_align_check #(.AW(AW)) u_align (
        .size       (size_q),
        .addr       (calc_ea),
        .access     (calc_acc),
        .misaligned (odd_fault)
    );

    // ---------------- outputs ----------------
    always_comb begin
        done         = 1'b0;
        ea           = '0;
        mem_access   = 1'b0;
        wb_en        = 1'b0;
        wb_val       = '0;
        extra_cycles = '0;
        addr_err     = 1'b0;
        unique case (state_q)
            ST_DONE: begin
                done       = 1'b1;
                ea         = calc_ea;
                addr_err   = odd_fault;
                mem_access = calc_acc && !odd_fault;
                wb_en      = calc_wb_en && !odd_fault;
                wb_val     = (calc_wb_en && !odd_fault) ? calc_wb : '0;
                if (mode_q == AM_PREDEC && !nopen_q)
                    extra_cycles = CW'(PENALTY);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW      = 32,
    parameter int CW      = 2,
    parameter int PENALTY = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          ext_valid,
    input logic          done,
    input logic [AW-1:0] ea,
    input logic          mem_access,
    input logic          wb_en,
    input logic          addr_err,
    input logic [CW-1:0] extra_cycles,
    input logic [1:0]    state_q
);

    // R2: outputs are quiet whenever no result is presented
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!mem_access && !wb_en && !addr_err && ea == '0 && extra_cycles == '0));

    // R2: result lasts exactly one cycle
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: first wait state holds without a strobe
    p_wait_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd1 && !ext_valid) |=> state_q == 2'd1);

    // R8: second word of an absolute long is awaited
    p_wait_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd2 && !ext_valid) |=> state_q == 2'd2);

    // R12: a request while waiting does not leave the wait state
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == 2'd1 && start && !ext_valid) |=> state_q == 2'd1);

    // R9: an address error blocks the access and the writeback, and only on odd addresses
    p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> (!mem_access && !wb_en && ea[0]));

    // R10: penalty value only appears with a result
    p_penalty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (extra_cycles != '0) |-> (done && extra_cycles == CW'(PENALTY)));

    // R11: writeback never happens without a memory access
    p_wb_needs_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> mem_access);

endmodule

bind ea_unit ea_unit_chk #(.AW(AW), .CW(CW), .PENALTY(PENALTY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .ext_valid    (ext_valid),
    .done         (done),
    .ea           (ea),
    .mem_access   (mem_access),
    .wb_en        (wb_en),
    .addr_err     (addr_err),
    .extra_cycles (extra_cycles),
    .state_q      (state_q)
);

// File: tb/tb_ea_unit.sv
`timescale 1ns/1ps
module tb_ea_unit;

    localparam int AW = 32, EXT_W = 16, NREG = 8, SP_REG = 7, PENALTY = 2;
    localparam int CW = $clog2(PENALTY + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       mode = '0;
    logic [2:0]       reg_num = '0;
    logic [1:0]       size = '0;
    logic [AW-1:0]    areg_val = '0;
    logic [AW-1:0]    pc_base = '0;
    logic             no_penalty = 1'b0;
    logic             ext_valid = 1'b0;
    logic [EXT_W-1:0] ext_word = '0;
    logic             done, mem_access, wb_en, addr_err;
    logic [AW-1:0]    ea, wb_val;
    logic [CW-1:0]    extra_cycles;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    ea_unit #(.AW(AW), .EXT_W(EXT_W), .NREG(NREG), .SP_REG(SP_REG), .PENALTY(PENALTY)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .reg_num(reg_num),
        .size(size), .areg_val(areg_val), .pc_base(pc_base), .no_penalty(no_penalty),
        .ext_valid(ext_valid), .ext_word(ext_word), .done(done), .ea(ea),
        .mem_access(mem_access), .wb_en(wb_en), .wb_val(wb_val),
        .extra_cycles(extra_cycles), .addr_err(addr_err)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_quiet(input string tag);
        n_checks++;
        if (done || mem_access || wb_en || addr_err || ea != '0 || wb_val != '0 || extra_cycles != '0) begin
            n_fail++;
            $display("FAIL %s quiet: done=%b acc=%b wb=%b err=%b ea=%h wbv=%h x=%0d expected 0 0 0 0 0 0 0",
                     tag, done, mem_access, wb_en, addr_err, ea, wb_val, extra_cycles);
        end
    endtask

    // One evaluation; reference computed from the requirements.
    task automatic run(input logic [2:0] m, input logic [2:0] r, input logic [1:0] sz,
                       input logic [31:0] av, input logic [31:0] pcv, input logic np,
                       input logic [15:0] w0, input logic [15:0] w1,
                       input int gap, input bit poke, input string tag);
        logic [31:0] st, e_ea, e_wbv, sx;
        logic        e_acc, e_wb, e_err;
        logic [1:0]  e_x;
        int          nw;
        st = (sz == 2'd0) ? ((r == 3'(SP_REG)) ? 32'd2 : 32'd1) : ((sz == 2'd1) ? 32'd2 : 32'd4);
        sx = {{16{w0[15]}}, w0};
        e_ea = '0; e_wbv = '0; e_acc = 1'b1; e_wb = 1'b0; e_x = 2'd0; nw = 0;
        case (m)
            3'd0: e_acc = 1'b0;
            3'd1: e_ea = av;
            3'd2: begin e_ea = av; e_wb = 1'b1; e_wbv = av + st; end
            3'd3: begin e_ea = av - st; e_wb = 1'b1; e_wbv = av - st; e_x = np ? 2'd0 : 2'd2; end
            3'd4: begin e_ea = av + sx; nw = 1; end
            3'd5: begin e_ea = pcv + sx; nw = 1; end
            3'd6: begin e_ea = sx; nw = 1; end
            default: begin e_ea = {w0, w1}; nw = 2; end
        endcase
        e_err = e_acc && (sz != 2'd0) && e_ea[0];
        if (e_err) begin e_acc = 1'b0; e_wb = 1'b0; e_wbv = '0; end

        mode = m; reg_num = r; size = sz; areg_val = av; pc_base = pcv; no_penalty = np;
        start = 1'b1;
        tick();
        start = 1'b0;
        // disturb captured inputs
        mode = ~m; reg_num = ~r; size = ~sz; areg_val = ~av; pc_base = ~pcv; no_penalty = ~np;
        for (int k = 0; k < nw; k++) begin
            check_quiet(tag);
            for (int g = 0; g < gap; g++) begin
                ext_valid = 1'b0;
                ext_word  = 16'hDEAD;
                start     = poke;
                tick();
                start = 1'b0;
                check_quiet(tag);
            end
            ext_valid = 1'b1;
            ext_word  = (k == 0) ? w0 : w1;
            tick();
            ext_valid = 1'b0;
            ext_word  = 16'h5A5A;
        end
        n_checks++;
        if (done !== 1'b1 || ea !== e_ea || mem_access !== e_acc || wb_en !== e_wb ||
            wb_val !== e_wbv || addr_err !== e_err || extra_cycles !== e_x) begin
            n_fail++;
            $display("FAIL %s result: done=%b ea=%h acc=%b wb=%b wbv=%h err=%b x=%0d expected done=1 ea=%h acc=%b wb=%b wbv=%h err=%b x=%0d",
                     tag, done, ea, mem_access, wb_en, wb_val, addr_err, extra_cycles,
                     e_ea, e_acc, e_wb, e_wbv, e_err, e_x);
        end
        tick();
        check_quiet(tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check_quiet("R1");
        tick();
        check_quiet("R1");
        rst_n = 1'b1;
        tick();
        check_quiet("R1");

        run(3'd0, 3'd2, 2'd2, 32'h1234_5678, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R11 direct");
        run(3'd1, 3'd1, 2'd1, 32'h0000_2000, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R11 indirect");
        run(3'd2, 3'd3, 2'd2, 32'h0000_1000, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R3 postinc long");
        run(3'd2, 3'd4, 2'd1, 32'h0000_3FFE, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R3 postinc word");
        run(3'd2, 3'd2, 2'd0, 32'h0000_0101, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R5 byte step 1");
        run(3'd2, 3'd7, 2'd0, 32'h0000_0800, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R5 byte step sp");
        run(3'd3, 3'd5, 2'd1, 32'h0000_4000, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R4 R10 predec word");
        run(3'd3, 3'd7, 2'd0, 32'h0000_0900, 32'h0, 1'b1, 16'h0, 16'h0, 0, 0, "R5 R10 predec sp nopen");
        run(3'd3, 3'd1, 2'd0, 32'h0000_0000, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R4 R5 predec wrap");
        run(3'd4, 3'd6, 2'd1, 32'h0001_0000, 32'h0, 1'b0, 16'hFFF0, 16'h0, 2, 0, "R6 disp neg");
        run(3'd4, 3'd0, 2'd2, 32'h0000_0100, 32'h0, 1'b0, 16'h7FFE, 16'h0, 0, 0, "R6 disp pos");
        run(3'd5, 3'd0, 2'd1, 32'h0, 32'h0000_8002, 1'b0, 16'h0040, 16'h0, 1, 0, "R7 pcrel pos");
        run(3'd5, 3'd0, 2'd2, 32'h0, 32'h0000_8002, 1'b0, 16'hFF00, 16'h0, 0, 0, "R7 pcrel neg");
        run(3'd6, 3'd0, 2'd1, 32'h0, 32'h0, 1'b0, 16'h8004, 16'h0, 0, 0, "R8 abs short");
        run(3'd7, 3'd0, 2'd2, 32'h0, 32'h0, 1'b0, 16'h00FC, 16'h1230, 3, 1, "R8 R12 abs long poke");
        run(3'd1, 3'd2, 2'd1, 32'h0000_2001, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R9 odd word");
        run(3'd1, 3'd2, 2'd0, 32'h0000_2001, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R9 odd byte ok");
        run(3'd2, 3'd3, 2'd2, 32'h0000_1003, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R9 odd postinc long");
        run(3'd3, 3'd3, 2'd1, 32'h0000_1003, 32'h0, 1'b0, 16'h0, 16'h0, 0, 0, "R9 R10 odd predec");
        run(3'd7, 3'd0, 2'd3, 32'h0, 32'h0, 1'b0, 16'h0001, 16'h0007, 0, 0, "R8 R9 abs long odd");
        run(3'd4, 3'd1, 2'd1, 32'h0000_0200, 32'h0, 1'b0, 16'h0003, 16'h0, 1, 1, "R2 R12 disp poke");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule